// File: doc/BRIEF.md
# Soft-Start and Fault Supervisor

This block decides when a switching power stage may run and how much on-time it may use. Each of four protection conditions arrives as a pair of single-cycle comparator flags: one says the trip level was crossed, the other says the release level was crossed. The block keeps its own hold bit per condition, so the analog hysteresis becomes a set/clear latch. The conditions are supply lockout, input undervoltage, input shutdown and over-temperature.

While every hold bit is clear, a digital ramp counter climbs by a programmable step each clock. Switching stays disabled through a dead interval until the ramp reaches a start level. After that, the duty ceiling rises linearly from the minimum duty toward the maximum duty, and then it holds at the maximum.

Any active condition stops switching on the next clock edge and drops the ramp to zero. When the last condition is released, a complete new soft-start follows, including its dead interval. Overcurrent events are not inputs to this block and never re-arm the ramp.

Top module: `softstart_supervisor`

## Requirements
- R1: During reset and after its release, `sw_en` and `duty_lim` are 0. All four hold bits come out of reset set, so no switching starts until each hold bit has been cleared by its own release flag.
- R2: A trip flag sampled at a clock edge makes `sw_en` 0 and `duty_lim` 0 from that same edge. This holds in every state.
- R3: A hold bit stays set after its trip flag drops and clears only on its release flag. When trip and release are both high on the same edge, the trip wins.
- R4: At the edge where the last hold bit clears, the ramp restarts at 0. It then adds `ss_step` on every later edge and saturates at full scale (2^RAMP_W-1) without wrapping.
- R5: `sw_en` stays 0 while the ramp is below START_LVL. It rises at the first edge where the ramp is at or above START_LVL.
- R6: While enabled and still ramping, `duty_lim` = DMIN + ((ramp − START_LVL) >> DUTY_SHIFT), capped at DMAX. Whenever `sw_en` is 0, `duty_lim` is 0.
- R7: Once the ceiling reaches DMAX, `sw_en` stays 1 and `duty_lim` stays DMAX until a condition trips. While enabled, the ceiling never falls.
- R8: Recovery from any tripped condition runs a full soft-start from ramp 0, with the same dead interval as a first start.
- R9: Bit positions in `flt_set`/`flt_clr`: bit 0 is supply lockout, bit 1 is input undervoltage, bit 2 is input shutdown, bit 3 is over-temperature. Each bit has the same effect on switching.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flt_set | input | NFLT | Per-condition trip flags (bit map in R9) |
| flt_clr | input | NFLT | Per-condition release flags (same bit map) |
| ss_step | input | STEP_W | Ramp increment per clock |
| sw_en | output | 1 | Switching enable to the drive sequencer |
| duty_lim | output | DUTY_W | Duty ceiling in units of 1/2^DUTY_W of a period |

## Verification
The assertions check the following on every cycle:
- A trip flag blanks the enable and the ceiling on the following edge.
- A disabled block shows a zero ceiling.
- An enabled ceiling stays inside the DMIN..DMAX window and never falls.
- The enable rises only with the ramp at or above the start level.
- The ramp never wraps.
- A hold bit cannot clear without its release flag.

Only the directed scenarios can show the following:
- The exact edge the dead interval ends for a given step.
- The exact ceiling values along the ramp.
- That every condition bit forces a complete re-run of soft-start.
- That a simultaneous trip and release keeps the block off.

// File: rtl/ssf_pkg.sv
package ssf_pkg;
  typedef enum logic [2:0] {
    ST_OFF   = 3'd0,
    ST_WAIT  = 3'd1,
    ST_RAMP  = 3'd2,
    ST_RUN   = 3'd3,
    ST_FAULT = 3'd4
  } ssf_state_e;
endpackage

// File: rtl/ssf_fault_hold.sv
// Per-condition set/clear hold bits: trip dominates release (R3).
module ssf_fault_hold #(
  parameter int          NFLT     = 4,
  parameter logic [NFLT-1:0] HOLD_RST = '1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NFLT-1:0] flt_set,
  input  logic [NFLT-1:0] flt_clr,
  output logic [NFLT-1:0] hold_q,
  output logic [NFLT-1:0] hold_d,
  output logic            any_d
);
  for (genvar i = 0; i < NFLT; i++) begin : g_bit
    assign hold_d[i] = flt_set[i] | (hold_q[i] & ~flt_clr[i]);
  end

  assign any_d = |hold_d;

  always_ff @(posedge clk) begin
    if (rst) hold_q <= HOLD_RST;
    else     hold_q <= hold_d;
  end
endmodule

// File: rtl/ssf_ramp.sv
// Saturating soft-start ramp counter (R4).
module ssf_ramp #(
  parameter int RAMP_W = 12,
  parameter int STEP_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear,
  input  logic [STEP_W-1:0] step,
  output logic [RAMP_W-1:0] ramp_q,
  output logic [RAMP_W-1:0] ramp_d
);
  localparam logic [RAMP_W-1:0] FULL = '1;
  localparam int SUM_W = RAMP_W + 1;

  logic [SUM_W-1:0] sum;

  always_comb begin
    sum = {1'b0, ramp_q} + SUM_W'(step);
    if (clear)            ramp_d = '0;
    else if (sum[RAMP_W]) ramp_d = FULL;
    else                  ramp_d = sum[RAMP_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) ramp_q <= '0;
    else     ramp_q <= ramp_d;
  end
endmodule

// File: rtl/ssf_duty_map.sv
// Maps the ramp value to a duty ceiling (R5, R6).
module ssf_duty_map #(
  parameter int RAMP_W     = 12,
  parameter int DUTY_W     = 8,
  parameter int START_LVL  = 600,
  parameter int DMIN       = 32,
  parameter int DMAX       = 236,
  parameter int DUTY_SHIFT = 4
) (
  input  logic [RAMP_W-1:0] ramp,
  output logic [DUTY_W-1:0] duty,
  output logic              past_start,
  output logic              at_cap
);
  localparam int SUM_W = ((RAMP_W > DUTY_W) ? RAMP_W : DUTY_W) + 1;

  logic [RAMP_W-1:0] excess;
  logic [SUM_W-1:0]  sum;

  always_comb begin
    past_start = (ramp >= RAMP_W'(START_LVL));
    excess     = past_start ? (ramp - RAMP_W'(START_LVL)) : '0;
    sum        = SUM_W'(DMIN) + SUM_W'(excess >> DUTY_SHIFT);
    at_cap     = past_start && (sum >= SUM_W'(DMAX));
    if (at_cap)          duty = DUTY_W'(DMAX);
    else if (past_start) duty = sum[DUTY_W-1:0];
    else                 duty = '0;
  end
endmodule

// File: rtl/softstart_supervisor.sv
// Top: supervisor state machine with registered enable and duty ceiling.
module softstart_supervisor
  import ssf_pkg::*;
#(
  parameter int NFLT       = 4,
  parameter int RAMP_W     = 12,
  parameter int STEP_W     = 8,
  parameter int DUTY_W     = 8,
  parameter int START_LVL  = 600,
  parameter int DMIN       = 32,
  parameter int DMAX       = 236,
  parameter int DUTY_SHIFT = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NFLT-1:0]   flt_set,
  input  logic [NFLT-1:0]   flt_clr,
  input  logic [STEP_W-1:0] ss_step,
  output logic              sw_en,
  output logic [DUTY_W-1:0] duty_lim
);
  localparam logic [NFLT-1:0] HOLD_RST = '1;

  ssf_state_e        state_q, state_d;
  logic [NFLT-1:0]   hold_q, hold_d;
  logic              any_d;
  logic              ramp_clear;
  logic [RAMP_W-1:0] ramp_q, ramp_d;
  logic [DUTY_W-1:0] map_duty;
  logic              past_start, at_cap;

  ssf_fault_hold #(.NFLT(NFLT), .HOLD_RST(HOLD_RST)) u_hold (
    .clk(clk), .rst(rst), .flt_set(flt_set), .flt_clr(flt_clr),
    .hold_q(hold_q), .hold_d(hold_d), .any_d(any_d)
  );

  // The ramp is forced to zero while idle, faulted, or about to fault.
  assign ramp_clear = any_d || (state_q == ST_OFF) || (state_q == ST_FAULT);

  ssf_ramp #(.RAMP_W(RAMP_W), .STEP_W(STEP_W)) u_ramp (
    .clk(clk), .rst(rst), .clear(ramp_clear), .step(ss_step),
    .ramp_q(ramp_q), .ramp_d(ramp_d)
  );

  ssf_duty_map #(
    .RAMP_W(RAMP_W), .DUTY_W(DUTY_W), .START_LVL(START_LVL),
    .DMIN(DMIN), .DMAX(DMAX), .DUTY_SHIFT(DUTY_SHIFT)
  ) u_map (
    .ramp(ramp_d), .duty(map_duty), .past_start(past_start), .at_cap(at_cap)
  );

  always_comb begin
    state_d = state_q;
    if (any_d) begin
      state_d = ST_FAULT;
    end else begin
      unique case (state_q)
        ST_OFF, ST_FAULT: state_d = ST_WAIT;
        ST_WAIT: begin
          if (at_cap)          state_d = ST_RUN;
          else if (past_start) state_d = ST_RAMP;
        end
        ST_RAMP: if (at_cap) state_d = ST_RUN;
        ST_RUN:  state_d = ST_RUN;
        default: state_d = ST_FAULT;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_OFF;
      sw_en    <= 1'b0;
      duty_lim <= '0;
    end else begin
      state_q  <= state_d;
      sw_en    <= (state_d == ST_RAMP) || (state_d == ST_RUN);
      if (state_d == ST_RUN)       duty_lim <= DUTY_W'(DMAX);
      else if (state_d == ST_RAMP) duty_lim <= map_duty;
      else                         duty_lim <= '0;
    end
  end
endmodule

// File: rtl/ssf_checker.sv
module ssf_checker #(
  parameter int NFLT      = 4,
  parameter int RAMP_W    = 12,
  parameter int DUTY_W    = 8,
  parameter int START_LVL = 600,
  parameter int DMIN      = 32,
  parameter int DMAX      = 236
) (
  input logic              clk,
  input logic              rst,
  input logic [NFLT-1:0]   flt_set,
  input logic [NFLT-1:0]   flt_clr,
  input logic              sw_en,
  input logic [DUTY_W-1:0] duty_lim,
  input logic [RAMP_W-1:0] ramp_q,
  input logic [NFLT-1:0]   hold_q
);
  p_fault_blanks_r2: assert property (@(posedge clk) disable iff (rst)
    (|flt_set) |=> (!sw_en && duty_lim == '0));

  p_idle_zero_r6: assert property (@(posedge clk) disable iff (rst)
    !sw_en |-> duty_lim == '0);

  p_duty_window_r6: assert property (@(posedge clk) disable iff (rst)
    sw_en |-> (duty_lim >= DUTY_W'(DMIN) && duty_lim <= DUTY_W'(DMAX)));

  p_duty_rises_r7: assert property (@(posedge clk) disable iff (rst)
    sw_en |=> (!sw_en || duty_lim >= $past(duty_lim)));

  p_enable_level_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(sw_en) |-> ramp_q >= RAMP_W'(START_LVL));

  p_no_overflow_r4: assert property (@(posedge clk) disable iff (rst)
    (ramp_q != '0) |-> ramp_q >= $past(ramp_q));

  for (genvar i = 0; i < NFLT; i++) begin : g_hold
    p_hold_kept_r3: assert property (@(posedge clk) disable iff (rst)
      (hold_q[i] && !flt_clr[i]) |=> hold_q[i]);
  end
endmodule

bind softstart_supervisor ssf_checker #(
  .NFLT(NFLT), .RAMP_W(RAMP_W), .DUTY_W(DUTY_W),
  .START_LVL(START_LVL), .DMIN(DMIN), .DMAX(DMAX)
) u_ssf_chk (
  .clk(clk), .rst(rst), .flt_set(flt_set), .flt_clr(flt_clr),
  .sw_en(sw_en), .duty_lim(duty_lim), .ramp_q(ramp_q), .hold_q(hold_q)
);

// File: tb/softstart_supervisor_bench.sv
module softstart_supervisor_bench;
  localparam int NFLT = 4;
  localparam int STEP_W = 8;
  localparam int DUTY_W = 8;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic              rst;
  logic [NFLT-1:0]   flt_set, flt_clr;
  logic [STEP_W-1:0] ss_step;
  logic              sw_en;
  logic [DUTY_W-1:0] duty_lim;

  int n_chk = 0;
  int n_err = 0;

  softstart_supervisor u_softstart_supervisor (
    .clk(clk), .rst(rst), .flt_set(flt_set), .flt_clr(flt_clr),
    .ss_step(ss_step), .sw_en(sw_en), .duty_lim(duty_lim)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Release every hold; afterwards the ramp is 0 in the wait state.
  task automatic bring_up(input int s);
    ss_step = STEP_W'(s);
    flt_clr = '1;
    tick(1);
    flt_clr = '0;
  endtask

  task automatic restart(input int s);
    flt_set = 4'b0001;
    tick(1);
    flt_set = '0;
    bring_up(s);
  endtask

  task automatic t_reset;
    rst = 1'b1; flt_set = '0; flt_clr = '0; ss_step = 8'd8;
    tick(3);
    chk("R1 sw_en in reset", sw_en, 0);
    chk("R1 duty in reset", duty_lim, 0);
    rst = 1'b0;
    tick(100);
    chk("R1 locked after reset", sw_en, 0);
    flt_clr = 4'b0111;
    tick(1);
    flt_clr = '0;
    tick(100);
    chk("R9 bit3 still holds", sw_en, 0);
    flt_clr = 4'b1000;
    tick(1);
    flt_clr = '0;
    tick(74);
    chk("R5 dead interval k=74", sw_en, 0);
    tick(1);
    chk("R5 enable at k=75", sw_en, 1);
    chk("R6 first ceiling DMIN", duty_lim, 32);
  endtask

  task automatic t_softstart;
    restart(8);
    chk("R4 ramp restarted off", sw_en, 0);
    chk("R6 duty zero while off", duty_lim, 0);
    tick(74);
    chk("R5 off at ramp 592", sw_en, 0);
    tick(1);
    chk("R5 on at ramp 600", sw_en, 1);
    chk("R6 duty at 600", duty_lim, 32);
    tick(2);
    chk("R6 duty at 616", duty_lim, 33);
    tick(198);
    chk("R6 duty at 2200", duty_lim, 132);
    tick(207);
    chk("R6 duty at 3856", duty_lim, 235);
    tick(1);
    chk("R7 duty reaches DMAX", duty_lim, 236);
    tick(100);
    chk("R7 holds DMAX", duty_lim, 236);
    chk("R4 saturated ramp keeps enable", sw_en, 1);
  endtask

  task automatic t_steps;
    restart(7);
    tick(85);
    chk("R5 step7 off at 595", sw_en, 0);
    tick(1);
    chk("R5 step7 on at 602", sw_en, 1);
    chk("R6 step7 duty", duty_lim, 32);
    restart(20);
    tick(29);
    chk("R5 step20 off at 580", sw_en, 0);
    tick(1);
    chk("R5 step20 on at 600", sw_en, 1);
    restart(255);
    tick(3);
    chk("R6 step255 duty at 765", duty_lim, 42);
    tick(12);
    chk("R6 step255 duty at 3825", duty_lim, 233);
    tick(1);
    chk("R6 cap at DMAX", duty_lim, 236);
    tick(1);
    chk("R4 saturation no wrap", duty_lim, 236);
    chk("R4 saturation enable", sw_en, 1);
  endtask

  task automatic t_each_fault;
    for (int b = 0; b < NFLT; b++) begin
      restart(255);
      tick(20);
      chk("R7 running before trip", duty_lim, 236);
      flt_set[b] = 1'b1;
      tick(1);
      flt_set = '0;
      chk($sformatf("R2 R9 bit%0d blanks enable", b), sw_en, 0);
      chk($sformatf("R2 R9 bit%0d blanks duty", b), duty_lim, 0);
      tick(5);
      chk($sformatf("R3 bit%0d held", b), sw_en, 0);
      flt_clr[b] = 1'b1;
      tick(1);
      flt_clr = '0;
      tick(2);
      chk($sformatf("R8 bit%0d dead interval", b), sw_en, 0);
      tick(1);
      chk($sformatf("R8 bit%0d restart duty", b), duty_lim, 42);
    end
  endtask

  task automatic t_midramp;
    restart(8);
    tick(40);
    flt_set = 4'b0100;
    tick(1);
    flt_set = '0;
    flt_clr = 4'b0100;
    tick(1);
    flt_clr = '0;
    tick(74);
    chk("R8 wait-state trip restarts ramp", sw_en, 0);
    tick(1);
    chk("R8 enable after full dead interval", sw_en, 1);
    tick(25);
    chk("R6 mid-ramp duty", duty_lim, 44);
    flt_set = 4'b0010;
    tick(1);
    flt_set = '0;
    chk("R2 mid-ramp trip enable", sw_en, 0);
    chk("R2 mid-ramp trip duty", duty_lim, 0);
  endtask

  task automatic t_dominant;
    restart(8);
    flt_set = 4'b1000;
    flt_clr = 4'b1000;
    tick(1);
    flt_set = '0;
    flt_clr = '0;
    tick(80);
    chk("R3 trip dominates release", sw_en, 0);
    bring_up(8);
    tick(75);
    chk("R3 release after dominance", sw_en, 1);
  endtask

  initial begin
    t_reset();
    t_softstart();
    t_steps();
    t_each_fault();
    t_midramp();
    t_dominant();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule